// File: doc/BRIEF.md
# Three-Ring Transmit Descriptor Sequencer

This block fetches transmit work for an Ethernet MAC that has three independent transmit rings. Software places 8-byte buffer descriptors in memory, programs a start address per ring, sets the global enable and then rings that ring's doorbell. One shared walker reads the ring's descriptors through a single-outstanding request/acknowledge memory port. It hands each ready buffer (address, length, last-of-frame marker) to a downstream framer over a valid/ready port. It then writes the descriptor back with its ready flag cleared, and moves to the next descriptor or back to the ring start when the wrap flag is set.

Every ring keeps its own current pointer, which survives between walks. A walk ends at the first descriptor that is not ready, or after `MAX_DESC` descriptors. Completion events for each ring are collected in a write-one-to-clear event register. An interrupt line is raised when any event bit is also set in a mask register. Doorbells that arrive while another ring is being walked wait as pending and are served lowest ring number first. Clearing the global enable cancels all doorbells, aborts a walk in progress and rewinds every ring to its start address.

Top module: `txring_seq`

## Requirements
- R1: Register word addresses are 0 control (bit 0 = global enable), 1 event, 2 mask, 4/5/6 start address of rings 0/1/2, and 8/9/10 doorbell of rings 0/1/2. A start-address write stores the value with bits 2:0 forced to zero, reads back that value, and loads the ring's current pointer with it.
- R2: A doorbell write while the global enable is 0 has no effect: the doorbell reads 0 and no buffer is handed out.
- R3: A doorbell reads 1 in bit 0 from the write until the walk of that ring has ended, and 0 afterwards. All doorbells read 0 after reset.
- R4: A descriptor is two words. Word 0 holds the length in bits 15:0 and flags in bits 31:16: ready = bit 31, wrap = bit 29, interrupt = bit 28, last = bit 27. Word 1 holds the buffer address. For each ready descriptor the buffer address and length are handed out once. Word 0 is then written back with only the ready bit cleared.
- R5: After a descriptor is processed, the next pointer is the ring start address if its wrap flag is set, and otherwise the current pointer plus 8.
- R6: A walk stops at a descriptor whose ready bit is 0. That descriptor is neither handed out nor written, and the ring's pointer stays on it for the next walk.
- R7: A walk processes at most MAX_DESC descriptors (default 8). The pointer is then kept at the next unprocessed descriptor.
- R8: A processed descriptor with the interrupt flag sets the ring's buffer-done event. If it also has the last flag, it sets the ring's frame-done event. Bit positions: ring 0 buffer 26 and frame 27, ring 1 buffer 2 and frame 3, ring 2 buffer 6 and frame 7. A descriptor without the interrupt flag sets no event.
- R9: Writing the event register clears the bits written as 1. The irq output is 1 exactly when some event bit is set together with its mask bit.
- R10: Writing 0 to the enable bit clears all three doorbells, abandons a walk in progress without writing back its descriptor, and reloads every ring pointer from its start address.
- R11: Doorbells that arrive during a walk are held pending. When the walker becomes free, the pending ring with the lowest number is served first.
- R12: A memory request keeps its address, direction and data unchanged until it is acknowledged. Addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| buf_valid | output | 1 | Buffer handoff valid |
| buf_ready | input | 1 | Framer accepts the buffer |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 16 | Buffer length in bytes |
| buf_last | output | 1 | Buffer ends a frame |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest situations to reach are those where several doorbells are pending at once, and where the enable is cleared in the middle of a walk. Both need the single walker to be held busy on a known ring. The bench does this by holding buf_ready low, which parks the walker at the handoff of one ring's descriptor. While it is parked, the bench writes the other doorbells or clears the enable, then releases the framer. It then reads the handoff order and the first buffer of the next walk to show the priority and the pointer reload. The maximum-walk limit is reached by laying more ready descriptors in a ring than one walk may take, and checking that a second doorbell continues from where the first walk stopped.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int NUM_RINGS  = 3;
   localparam int REG_AW     = 4;
   localparam int DESC_BYTES = 8;

   localparam logic [REG_AW-1:0] ADR_CTRL  = 4'h0;
   localparam logic [REG_AW-1:0] ADR_EVENT = 4'h1;
   localparam logic [REG_AW-1:0] ADR_MASK  = 4'h2;
   localparam logic [REG_AW-1:0] ADR_START = 4'h4;
   localparam logic [REG_AW-1:0] ADR_BELL  = 4'h8;

   // flag positions inside descriptor word 0
   localparam int FLG_READY = 31;
   localparam int FLG_WRAP  = 29;
   localparam int FLG_INTR  = 28;
   localparam int FLG_LAST  = 27;

   typedef enum logic [2:0] {
      W_IDLE, W_HDR, W_BUF, W_HAND, W_WB, W_FIN
   } walk_state_t;

   function automatic logic [31:0] buf_done_bit(input logic [1:0] ring);
      case (ring)
         2'd0:    return 32'h1 << 26;
         2'd1:    return 32'h1 << 2;
         default: return 32'h1 << 6;
      endcase
   endfunction

   function automatic logic [31:0] frame_done_bit(input logic [1:0] ring);
      return buf_done_bit(ring) << 1;
   endfunction
endpackage

// File: rtl/txr_arbiter.sv
module txr_arbiter #(
   parameter int NR = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NR-1:0] req,
   output logic [NR-1:0] grant
);
   logic [NR:0] taken;
   assign taken[0] = 1'b0;

   for (genvar g = 0; g < NR; g++) begin : g_prio
      assign grant[g]   = req[g] & ~taken[g];
      assign taken[g+1] = taken[g] | req[g];
   end

   // R11: never more than one ring granted
   assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R11: ring 0 wins whenever it asks
   assert_ring0_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> grant[0]);
endmodule

// File: rtl/txr_regs.sv
module txr_regs
   import txr_pkg::*;
#(
   parameter int AW = 32,
   parameter int NR = NUM_RINGS,
   localparam int RW = $clog2(NR)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [REG_AW-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic                   upd_valid,
   input  logic [RW-1:0]          upd_ring,
   input  logic [AW-1:0]          upd_ptr,
   input  logic                   done,
   input  logic [RW-1:0]          done_ring,
   input  logic [31:0]            ev_set,
   output logic                   en_o,
   output logic [NR-1:0]          pend_o,
   output logic [NR-1:0][AW-1:0]  start_o,
   output logic [NR-1:0][AW-1:0]  cur_o,
   output logic                   irq
);
   logic        en_q;
   logic [31:0] ev_q, mask_q;
   logic        wr_ctrl, disable_wr, wr_event, wr_mask;
   logic [NR-1:0] start_wr, bell_wr;
   logic [AW-1:0] aligned;

   assign wr_ctrl    = reg_wr && (reg_addr == ADR_CTRL);
   assign disable_wr = wr_ctrl && !reg_wdata[0];
   assign wr_event   = reg_wr && (reg_addr == ADR_EVENT);
   assign wr_mask    = reg_wr && (reg_addr == ADR_MASK);
   assign aligned    = {reg_wdata[AW-1:3], 3'b000};

   always_comb begin
      for (int r = 0; r < NR; r++) begin
         start_wr[r] = reg_wr && (reg_addr == ADR_START + REG_AW'(r));
         bell_wr[r]  = reg_wr && (reg_addr == ADR_BELL + REG_AW'(r));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ev_q   <= '0;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) en_q <= reg_wdata[0];
         if (wr_mask) mask_q <= reg_wdata;
         ev_q <= (ev_q & ~(wr_event ? reg_wdata : 32'h0)) | ev_set;
      end
   end

   for (genvar g = 0; g < NR; g++) begin : g_ring
      logic [AW-1:0] start_r, cur_r;
      logic          pend_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_r <= '0;
            cur_r   <= '0;
            pend_r  <= 1'b0;
         end else begin
            if (start_wr[g]) start_r <= aligned;
            if (disable_wr)
               cur_r <= start_r;
            else if (start_wr[g])
               cur_r <= aligned;
            else if (en_q && upd_valid && upd_ring == RW'(g))
               cur_r <= upd_ptr;
            if (disable_wr)
               pend_r <= 1'b0;
            else if (bell_wr[g] && en_q)
               pend_r <= 1'b1;
            else if (done && done_ring == RW'(g))
               pend_r <= 1'b0;
         end
      end
      assign start_o[g] = start_r;
      assign cur_o[g]   = cur_r;
      assign pend_o[g]  = pend_r;
   end

   assign en_o = en_q;
   assign irq  = |(ev_q & mask_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_CTRL:  reg_rdata[0] = en_q;
         ADR_EVENT: reg_rdata    = ev_q;
         ADR_MASK:  reg_rdata    = mask_q;
         default: begin
            for (int r = 0; r < NR; r++) begin
               if (reg_addr == ADR_START + REG_AW'(r)) reg_rdata = 32'(start_o[r]);
               if (reg_addr == ADR_BELL + REG_AW'(r))  reg_rdata = {31'b0, pend_o[r]};
            end
         end
      endcase
   end

   // R9: bits written as one are gone next cycle when nothing sets them
   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_event && ev_set == 32'h0) |=> ((ev_q & $past(reg_wdata)) == 32'h0));
   // R10: disabling drops every doorbell and rewinds every pointer
   assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      disable_wr |=> (pend_o == '0 && cur_o == $past(start_o)));
   // R2: while disabled, no doorbell becomes pending
   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (pend_o == '0));
endmodule

// File: rtl/txr_walker.sv
module txr_walker
   import txr_pkg::*;
#(
   parameter int AW       = 32,
   parameter int NR       = NUM_RINGS,
   parameter int MAX_DESC = 8,
   localparam int RW = $clog2(NR),
   localparam int CW = $clog2(MAX_DESC + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [NR-1:0]          grant,
   input  logic [NR-1:0][AW-1:0]  start_i,
   input  logic [NR-1:0][AW-1:0]  cur_i,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_addr,
   output logic [31:0]            mem_wdata,
   input  logic                   mem_ack,
   input  logic [31:0]            mem_rdata,
   output logic                   buf_valid,
   input  logic                   buf_ready,
   output logic [31:0]            buf_addr,
   output logic [15:0]            buf_len,
   output logic                   buf_last,
   output logic                   upd_valid,
   output logic [RW-1:0]          upd_ring,
   output logic [AW-1:0]          upd_ptr,
   output logic                   done,
   output logic [RW-1:0]          done_ring,
   output logic [31:0]            ev_set
);
   walk_state_t   st_q;
   logic [RW-1:0] ring_q, pick;
   logic [AW-1:0] ptr_q, next_ptr;
   logic [31:0]   hdr_q, bptr_q;
   logic [CW-1:0] cnt_q;
   logic          wb_done;

   always_comb begin
      pick = '0;
      for (int i = NR - 1; i >= 0; i--)
         if (grant[i]) pick = RW'(i);
   end

   assign next_ptr = hdr_q[FLG_WRAP] ? start_i[ring_q] : ptr_q + AW'(DESC_BYTES);
   assign wb_done  = en && (st_q == W_WB) && mem_ack;

   assign mem_req   = en && (st_q == W_HDR || st_q == W_BUF || st_q == W_WB);
   assign mem_we    = (st_q == W_WB);
   assign mem_addr  = (st_q == W_BUF) ? ptr_q + AW'(4) : ptr_q;
   assign mem_wdata = hdr_q & ~(32'h1 << FLG_READY);

   assign buf_valid = en && (st_q == W_HAND);
   assign buf_addr  = bptr_q;
   assign buf_len   = hdr_q[15:0];
   assign buf_last  = hdr_q[FLG_LAST];

   assign upd_valid = wb_done;
   assign upd_ring  = ring_q;
   assign upd_ptr   = next_ptr;
   assign done      = (st_q == W_FIN);
   assign done_ring = ring_q;

   always_comb begin
      ev_set = '0;
      if (wb_done && hdr_q[FLG_INTR]) begin
         ev_set = buf_done_bit(2'(ring_q));
         if (hdr_q[FLG_LAST]) ev_set = ev_set | frame_done_bit(2'(ring_q));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         ring_q <= '0;
         ptr_q  <= '0;
         hdr_q  <= '0;
         bptr_q <= '0;
         cnt_q  <= '0;
      end else if (!en) begin
         st_q <= W_IDLE;
      end else begin
         case (st_q)
            W_IDLE: if (|grant) begin
               ring_q <= pick;
               ptr_q  <= cur_i[pick];
               cnt_q  <= '0;
               st_q   <= W_HDR;
            end
            W_HDR: if (mem_ack) begin
               hdr_q <= mem_rdata;
               st_q  <= mem_rdata[FLG_READY] ? W_BUF : W_FIN;
            end
            W_BUF: if (mem_ack) begin
               bptr_q <= mem_rdata;
               st_q   <= W_HAND;
            end
            W_HAND: if (buf_ready) st_q <= W_WB;
            W_WB: if (mem_ack) begin
               ptr_q <= next_ptr;
               cnt_q <= cnt_q + 1'b1;
               st_q  <= (cnt_q == CW'(MAX_DESC - 1)) ? W_FIN : W_HDR;
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end

   // R12: an unanswered request stays put
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
   // R12: word-aligned accesses only
   assert_word_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));
   // R4: the write-back never carries the ready flag
   assert_wb_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[FLG_READY]);
   // R4: an offered buffer is held until taken
   assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));
   // R7: the per-walk count never passes the limit
   assert_walk_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_DESC));
endmodule

// File: rtl/txring_seq.sv
module txring_seq
   import txr_pkg::*;
#(
   parameter int AW       = 32,
   parameter int MAX_DESC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              buf_valid,
   input  logic              buf_ready,
   output logic [31:0]       buf_addr,
   output logic [15:0]       buf_len,
   output logic              buf_last,
   output logic              irq
);
   localparam int NR = NUM_RINGS;
   localparam int RW = $clog2(NR);

   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("txring_seq: AW must lie in 12..32");
   end
   if (MAX_DESC < 1) begin : g_bad_max
      $error("txring_seq: MAX_DESC must be at least 1");
   end

   logic                  en, upd_valid, done;
   logic [RW-1:0]         upd_ring, done_ring;
   logic [AW-1:0]         upd_ptr;
   logic [31:0]           ev_set;
   logic [NR-1:0]         pend, grant;
   logic [NR-1:0][AW-1:0] start_v, cur_v;

   txr_regs #(.AW(AW), .NR(NR)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_valid(upd_valid),
      .upd_ring(upd_ring), .upd_ptr(upd_ptr), .done(done), .done_ring(done_ring),
      .ev_set(ev_set), .en_o(en), .pend_o(pend), .start_o(start_v), .cur_o(cur_v),
      .irq(irq)
   );

   txr_arbiter #(.NR(NR)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(pend), .grant(grant)
   );

   txr_walker #(.AW(AW), .NR(NR), .MAX_DESC(MAX_DESC)) u_walk (
      .clk(clk), .rst_n(rst_n), .en(en), .grant(grant), .start_i(start_v),
      .cur_i(cur_v), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
      .buf_len(buf_len), .buf_last(buf_last), .upd_valid(upd_valid),
      .upd_ring(upd_ring), .upd_ptr(upd_ptr), .done(done), .done_ring(done_ring),
      .ev_set(ev_set)
   );
endmodule

// File: tb/txring_seq_test.sv
module txring_seq_test;
   import txr_pkg::*;
   localparam int CLK_PERIOD = 10;

   localparam logic [15:0] F_RDY  = 16'h8000;
   localparam logic [15:0] F_WRAP = 16'h2000;
   localparam logic [15:0] F_INT  = 16'h1000;
   localparam logic [15:0] F_LAST = 16'h0800;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   wire  [31:0] reg_rdata;
   wire         mem_req, mem_we;
   wire  [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   wire         buf_valid;
   logic        buf_ready = 1'b1;
   wire  [31:0] buf_addr;
   wire  [15:0] buf_len;
   wire         buf_last, irq;

   int checks = 0, fails = 0;
   logic [31:0] mem [0:255];
   logic        bd_we = 1'b0;
   logic [7:0]  bd_idx = '0;
   logic [31:0] bd_data = '0;
   int          hcnt = 0;
   logic [31:0] hlog_addr [0:63];
   logic [15:0] hlog_len  [0:63];
   logic        tb_en = 1'b0;
   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;
   int          hold_viol = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txring_seq uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_valid(buf_valid),
      .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
      .buf_last(buf_last), .irq(irq)
   );

   // memory model, handoff recorder and request-hold monitor
   always @(posedge clk) begin
      if (bd_we) mem[bd_idx] <= bd_data;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:2]];
      end else begin
         mem_ack <= 1'b0;
      end
      if (buf_valid && buf_ready) begin
         hlog_addr[hcnt[5:0]] <= buf_addr;
         hlog_len[hcnt[5:0]]  <= buf_len;
         hcnt <= hcnt + 1;
      end
      if (prev_wait && tb_en && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
      prev_wait <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic bd_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_idx = a[9:2]; bd_data = d;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   task automatic set_desc(input logic [31:0] a, input logic [15:0] len,
                           input logic [15:0] flags, input logic [31:0] bp);
      bd_write(a, {flags, len});
      bd_write(a + 4, bp);
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      if (a == ADR_CTRL) tb_en = d[0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] a, b, c;
      int n;
      n = 0;
      do begin
         reg_read(ADR_BELL, a); reg_read(ADR_BELL + 1, b); reg_read(ADR_BELL + 2, c);
         n++;
      end while (((a | b | c) != 0) && n < 3000);
      chk("R3 walk end", 32'(n >= 3000), 32'h0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 1'b0; buf_ready = 1'b1; tb_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_reset();
      logic [31:0] v;
      do_reset();
      reg_read(ADR_CTRL, v);      chk("R1 ctrl after reset", v, 32'h0);
      reg_read(ADR_EVENT, v);     chk("R9 event after reset", v, 32'h0);
      for (int r = 0; r < 3; r++) begin
         reg_read(ADR_BELL + 4'(r), v); chk("R3 doorbell after reset", v, 32'h0);
      end
      chk("R9 irq after reset", 32'(irq), 32'h0);
   endtask

   task automatic test_disabled();
      logic [31:0] v;
      int base;
      do_reset();
      reg_write(ADR_START, 32'h0);
      set_desc(32'h000, 16, F_RDY | F_INT | F_LAST, 32'h1000);
      base = hcnt;
      reg_write(ADR_BELL, 32'h1);
      repeat (20) @(negedge clk);
      reg_read(ADR_BELL, v);   chk("R2 doorbell ignored", v, 32'h0);
      chk("R2 no handoff", 32'(hcnt - base), 32'h0);
      chk("R2 descriptor untouched", mem[0], {F_RDY | F_INT | F_LAST, 16'd16});
   endtask

   task automatic test_basic();
      logic [31:0] v;
      int base;
      do_reset();
      set_desc(32'h100, 60, F_RDY | F_INT, 32'h2000);
      set_desc(32'h108, 40, F_RDY | F_INT | F_LAST | F_WRAP, 32'h2100);
      set_desc(32'h110, 5, F_RDY, 32'h2200);
      reg_write(ADR_START + 1, 32'h107);
      reg_read(ADR_START + 1, v);  chk("R1 start aligned", v, 32'h100);
      reg_write(ADR_CTRL, 32'h1);
      base = hcnt;
      reg_write(ADR_BELL + 1, 32'h1);
      reg_read(ADR_BELL + 1, v);   chk("R3 doorbell active", v, 32'h1);
      wait_idle();
      reg_read(ADR_BELL + 1, v);   chk("R3 doorbell cleared", v, 32'h0);
      chk("R5 two buffers then wrap", 32'(hcnt - base), 32'h2);
      chk("R1 first read at start", hlog_addr[base[5:0]], 32'h2000);
      chk("R4 first length", 32'(hlog_len[base[5:0]]), 32'd60);
      chk("R5 advance by 8", hlog_addr[6'(base + 1)], 32'h2100);
      chk("R4 write-back 0", mem[8'h40], {F_INT, 16'd60});
      chk("R4 write-back 1", mem[8'h42], {F_INT | F_LAST | F_WRAP, 16'd40});
      chk("R5 wrap skips next slot", mem[8'h44], {F_RDY, 16'd5});
      reg_read(ADR_EVENT, v);      chk("R8 ring1 events", v, 32'h0000_000C);
      bd_write(32'h100, {F_RDY, 16'd60});
      base = hcnt;
      reg_write(ADR_BELL + 1, 32'h1);
      wait_idle();
      chk("R5 resumed at start", 32'(hcnt - base), 32'h1);
      chk("R5 resumed buffer", hlog_addr[base[5:0]], 32'h2000);
   endtask

   task automatic test_events();
      logic [31:0] v;
      do_reset();
      reg_write(ADR_CTRL, 32'h1);
      set_desc(32'h000, 8, F_RDY | F_INT | F_LAST | F_WRAP, 32'h3000);
      set_desc(32'h200, 8, F_RDY | F_INT | F_WRAP, 32'h3100);
      set_desc(32'h100, 8, F_RDY | F_LAST | F_WRAP, 32'h3200);
      reg_write(ADR_START, 32'h000);
      reg_write(ADR_START + 2, 32'h200);
      reg_write(ADR_START + 1, 32'h100);
      reg_write(ADR_BELL, 32'h1);     wait_idle();
      reg_read(ADR_EVENT, v);  chk("R8 ring0 bits 26/27", v, 32'h0C00_0000);
      reg_write(ADR_BELL + 2, 32'h1); wait_idle();
      reg_read(ADR_EVENT, v);  chk("R8 ring2 buffer bit 6", v, 32'h0C00_0040);
      reg_write(ADR_BELL + 1, 32'h1); wait_idle();
      reg_read(ADR_EVENT, v);  chk("R8 no interrupt flag", v, 32'h0C00_0040);
      reg_write(ADR_MASK, 32'h40);
      chk("R9 irq masked event", 32'(irq), 32'h1);
      reg_write(ADR_EVENT, 32'h40);
      chk("R9 irq after clear", 32'(irq), 32'h0);
      reg_read(ADR_EVENT, v);  chk("R9 partial clear", v, 32'h0C00_0000);
      reg_write(ADR_MASK, 32'hFFFF_FFFF);
      chk("R9 irq full mask", 32'(irq), 32'h1);
      reg_write(ADR_EVENT, 32'h0C00_0000);
      reg_read(ADR_EVENT, v);  chk("R9 all cleared", v, 32'h0);
      chk("R9 irq low", 32'(irq), 32'h0);
   endtask

   task automatic test_notready();
      int base;
      do_reset();
      reg_write(ADR_CTRL, 32'h1);
      reg_write(ADR_START, 32'h000);
      set_desc(32'h000, 12, F_RDY, 32'h4000);
      set_desc(32'h008, 0, 16'h0000, 32'h4008);
      base = hcnt;
      reg_write(ADR_BELL, 32'h1); wait_idle();
      chk("R6 stop at not-ready", 32'(hcnt - base), 32'h1);
      chk("R6 not-ready untouched", mem[8'h02], 32'h0);
      bd_write(32'h008, {F_RDY | F_WRAP, 16'd9});
      base = hcnt;
      reg_write(ADR_BELL, 32'h1); wait_idle();
      chk("R6 pointer kept", hlog_addr[base[5:0]], 32'h4008);
   endtask

   task automatic test_max();
      int base;
      do_reset();
      reg_write(ADR_CTRL, 32'h1);
      reg_write(ADR_START + 1, 32'h100);
      for (int i = 0; i < 10; i++)
         set_desc(32'h100 + 32'(8 * i), 16'(i + 1), (i == 9) ? (F_RDY | F_WRAP) : F_RDY,
                  32'h5000 + 32'(i));
      base = hcnt;
      reg_write(ADR_BELL + 1, 32'h1); wait_idle();
      chk("R7 limit per walk", 32'(hcnt - base), 32'd8);
      chk("R7 last in first walk", hlog_addr[6'(base + 7)], 32'h5007);
      chk("R7 ninth still ready", mem[8'h50], {F_RDY, 16'd9});
      base = hcnt;
      reg_write(ADR_BELL + 1, 32'h1); wait_idle();
      chk("R7 second walk count", 32'(hcnt - base), 32'd2);
      chk("R7 second walk resumes", hlog_addr[base[5:0]], 32'h5008);
   endtask

   task automatic test_priority();
      logic [31:0] v;
      int base;
      do_reset();
      reg_write(ADR_CTRL, 32'h1);
      reg_write(ADR_START, 32'h000);
      reg_write(ADR_START + 1, 32'h100);
      reg_write(ADR_START + 2, 32'h200);
      set_desc(32'h000, 4, F_RDY | F_WRAP, 32'h6000);
      set_desc(32'h100, 4, F_RDY | F_WRAP, 32'h6100);
      set_desc(32'h200, 4, F_RDY | F_WRAP, 32'h6200);
      @(negedge clk); buf_ready = 1'b0;
      base = hcnt;
      reg_write(ADR_BELL + 1, 32'h1);
      repeat (10) @(negedge clk);
      reg_write(ADR_BELL + 2, 32'h1);
      reg_write(ADR_BELL, 32'h1);
      reg_read(ADR_BELL, v);     chk("R11 ring0 pending", v, 32'h1);
      reg_read(ADR_BELL + 2, v); chk("R11 ring2 pending", v, 32'h1);
      @(negedge clk); buf_ready = 1'b1;
      wait_idle();
      chk("R11 three walks", 32'(hcnt - base), 32'h3);
      chk("R11 busy ring first", hlog_addr[base[5:0]], 32'h6100);
      chk("R11 ring0 before ring2", hlog_addr[6'(base + 1)], 32'h6000);
      chk("R11 ring2 last", hlog_addr[6'(base + 2)], 32'h6200);
   endtask

   task automatic test_disable();
      logic [31:0] v;
      int base;
      do_reset();
      reg_write(ADR_CTRL, 32'h1);
      reg_write(ADR_START, 32'h000);
      reg_write(ADR_START + 2, 32'h200);
      set_desc(32'h000, 4, F_RDY, 32'h7000);
      set_desc(32'h008, 4, F_RDY, 32'h7008);
      set_desc(32'h010, 0, 16'h0000, 32'h7010);
      set_desc(32'h200, 4, F_RDY | F_WRAP, 32'h7200);
      reg_write(ADR_BELL, 32'h1); wait_idle();
      bd_write(32'h000, {F_RDY, 16'd4});
      @(negedge clk); buf_ready = 1'b0;
      reg_write(ADR_BELL + 2, 32'h1);
      repeat (10) @(negedge clk);
      reg_write(ADR_CTRL, 32'h0);
      reg_read(ADR_BELL + 2, v);  chk("R10 doorbell cleared", v, 32'h0);
      chk("R10 handoff withdrawn", 32'(buf_valid), 32'h0);
      @(negedge clk); buf_ready = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 no write-back", mem[8'h80], {F_RDY | F_WRAP, 16'd4});
      reg_write(ADR_CTRL, 32'h1);
      base = hcnt;
      reg_write(ADR_BELL, 32'h1); wait_idle();
      chk("R10 pointer rewound", hlog_addr[base[5:0]], 32'h7000);
      chk("R12 request held until ack", 32'(hold_viol), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      test_reset();
      test_disabled();
      test_basic();
      test_events();
      test_notready();
      test_max();
      test_priority();
      test_disable();
      report();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end
endmodule